// File: doc/BRIEF.md
# Pixel Round, Limit and Pack Unit

This unit sits between a pixel pipeline and a memory writer. Each cycle it may take one 40-bit processed pixel word, marked by a valid strobe. It reshapes that word into a 32-bit output word, which also carries a valid strobe. A static mode input picks the output layout. The layouts are raw sensor samples of 8 to 12 bits, a single luma byte, 16-bit or 32-bit packed RGB with a constant alpha, and four-byte YCbCr in either full or limited range.

The YCbCr input fields are 10 bits wide. Each is reduced to 8 bits by rounding half up, and the result saturates at 255 so that it never wraps. The limited-range option then clamps luma and chroma to their broadcast ranges. Every bit that a mode does not use is driven to zero. Mode codes that are not assigned pass the low 32 input bits through unchanged. The datapath has a single register stage.

Top module: `pixel_pack`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `out_valid` and `out_data` to zero.
- R2: `out_valid` equals the `in_valid` value sampled at the previous rising edge. `out_data` loads only on an edge where `in_valid` is high, and holds its value otherwise.
- R3: Raw modes, codes 0 to 4, give N = 8 + code bits. The output is `in_data[11:12-N]`, right-aligned in `out_data`, with all higher bits zero.
- R4: Luma mode 5 outputs round8(`in_data[29:20]`) in bits [7:0]. Luma mode 6 outputs the truncated value `in_data[29:22]` in bits [7:0]. In both modes bits [31:8] are zero.
- R5: Mode 7 (4-4-4-4) outputs `{16'b0, alpha[7:4], in[29:26], in[19:16], in[9:6]}`.
- R6: Mode 8 (1-5-5-5) outputs `{16'b0, alpha[7], in[29:25], in[19:15], in[9:5]}`.
- R7: Mode 9 (5-6-5) outputs `{16'b0, in[29:25], in[19:14], in[9:5]}`.
- R8: Mode 10 (8-8-8-8) outputs `{alpha, in[29:22], in[19:12], in[9:2]}`.
- R9: Mode 11 (full-range YCbCr) outputs four bytes, from the top byte down: round8(in[39:30]), round8(in[29:20]), round8(in[19:10]) and round8(in[9:0]). For a 10-bit value v, round8(v) is min(v[9:2] + v[1], 255).
- R10: Mode 12 (limited-range YCbCr) uses the same bytes as R9, then clamps them. The two upper (luma) bytes are clamped to 16..235 and the two lower (chroma) bytes to 16..240.
- R11: Mode codes 13 to 15 output `in_data[31:0]` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 4 | Output format code (static) |
| alpha | input | 8 | Constant alpha for RGB modes (static) |
| in_valid | input | 1 | Input word valid |
| in_data | input | 40 | Processed pixel word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Packed output word |

## Verification
The raw modes use an input whose bits above bit 11 are all ones, so any leak of an upper bit shows up in the zero-filled field. The RGB modes use one input word with an irregular bit pattern, so a field taken from a bit range shifted by one position gives a different result. The YCbCr and rounded-luma modes use fields chosen to separate the rounding cases: a round-up that saturates at all ones, a round-up into a new byte value, a case with no round-up, and an exact value. The limited mode adds fields at both range ends and a mid value, which show whether luma and chroma get separate upper limits and whether values inside the range pass untouched.

// File: rtl/pixel_pack.sv
module pixel_pack #(
  parameter int Y_LO = 16,
  parameter int Y_HI = 235,
  parameter int C_LO = 16,
  parameter int C_HI = 240
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  mode,
  input  logic [7:0]  alpha,
  input  logic        in_valid,
  input  logic [39:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_data
);

  localparam logic [7:0] YL = 8'(Y_LO);
  localparam logic [7:0] YH = 8'(Y_HI);
  localparam logic [7:0] CL = 8'(C_LO);
  localparam logic [7:0] CH = 8'(C_HI);

  function automatic logic [7:0] round8(input logic [9:0] v);
    logic [8:0] s;
    s = {1'b0, v[9:2]} + {8'b0, v[1]};
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  function automatic logic [7:0] clamp8(input logic [7:0] v, input logic [7:0] lo,
                                        input logic [7:0] hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  logic [31:0] yc_full, yc_lim;

  for (genvar i = 0; i < 4; i++) begin : g_comp
    localparam bit LUMA = (i >= 2);
    logic [7:0] r;
    assign r = round8(in_data[10*i+9 -: 10]);
    assign yc_full[8*i+7 -: 8] = r;
    assign yc_lim[8*i+7 -: 8]  = LUMA ? clamp8(r, YL, YH) : clamp8(r, CL, CH);
  end

  logic [31:0] packed_w;

  always_comb begin
    case (mode)
      4'd0:  packed_w = {24'b0, in_data[11:4]};
      4'd1:  packed_w = {23'b0, in_data[11:3]};
      4'd2:  packed_w = {22'b0, in_data[11:2]};
      4'd3:  packed_w = {21'b0, in_data[11:1]};
      4'd4:  packed_w = {20'b0, in_data[11:0]};
      4'd5:  packed_w = {24'b0, yc_full[23:16]};
      4'd6:  packed_w = {24'b0, in_data[29:22]};
      4'd7:  packed_w = {16'b0, alpha[7:4], in_data[29:26], in_data[19:16], in_data[9:6]};
      4'd8:  packed_w = {16'b0, alpha[7], in_data[29:25], in_data[19:15], in_data[9:5]};
      4'd9:  packed_w = {16'b0, in_data[29:25], in_data[19:14], in_data[9:5]};
      4'd10: packed_w = {alpha, in_data[29:22], in_data[19:12], in_data[9:2]};
      4'd11: packed_w = yc_full;
      4'd12: packed_w = yc_lim;
      default: packed_w = in_data[31:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= packed_w;
    end
  end

endmodule

// File: rtl/pixel_pack_chk.sv
module pixel_pack_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  mode,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] out_data
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == 32'b0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  a_r3_raw_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode <= 4'd4) |=> out_data[31:12] == 20'b0);

  a_r4_luma_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 4'd5 || mode == 4'd6)) |=> out_data[31:8] == 24'b0);

  a_r7_rgb16_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode >= 4'd7 && mode <= 4'd9) |=> out_data[31:16] == 16'b0);

  a_r10_luma_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 4'd12) |=>
      (out_data[31:24] >= 8'd16 && out_data[31:24] <= 8'd235 &&
       out_data[23:16] >= 8'd16 && out_data[23:16] <= 8'd235));

  a_r10_chroma_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 4'd12) |=>
      (out_data[15:8] >= 8'd16 && out_data[15:8] <= 8'd240 &&
       out_data[7:0] >= 8'd16 && out_data[7:0] <= 8'd240));

endmodule

bind pixel_pack pixel_pack_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_pixel_pack.sv
module sim_pixel_pack;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  mode = 4'd0;
  logic [7:0]  alpha = 8'hC5;
  logic        in_valid = 1'b0;
  logic [39:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_pack u0 (
    .clk(clk), .rst(rst), .mode(mode), .alpha(alpha),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one word, check the loaded result, then check the idle hold
  task automatic send(input string tag, input logic [3:0] m, input logic [39:0] d,
                      input logic [31:0] exp);
    @(negedge clk);
    mode = m; in_data = d; in_valid = 1'b1;
    @(negedge clk);
    chk({tag, " R2 valid"}, {31'b0, out_valid}, 32'd1);
    chk(tag, out_data, exp);
    in_valid = 1'b0; in_data = ~d;
    @(negedge clk);
    chk("R2 valid drop", {31'b0, out_valid}, 32'd0);
    chk("R2 data hold", out_data, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid", {31'b0, out_valid}, 32'd0);
    chk("R1 data", out_data, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_raw;
    logic [39:0] d = 40'hFF_FFFF_FABC;
    send("R3 raw8",  4'd0, d, 32'h0000_00AB);
    send("R3 raw9",  4'd1, d, 32'h0000_0157);
    send("R3 raw10", 4'd2, d, 32'h0000_02AF);
    send("R3 raw11", 4'd3, d, 32'h0000_055E);
    send("R3 raw12", 4'd4, d, 32'h0000_0ABC);
  endtask

  task automatic t_luma;
    send("R4 luma round sat", 4'd5, {10'h000, 10'h3FF, 20'hFFFFF}, 32'h0000_00FF);
    send("R4 luma round up",  4'd5, {10'h3FF, 10'h0FE, 20'h00000}, 32'h0000_0040);
    send("R4 luma trunc",     4'd6, {10'h3FF, 10'h0FE, 20'hFFFFF}, 32'h0000_003F);
  endtask

  task automatic t_rgb;
    logic [39:0] d = 40'h5A_C3F0_96E7;
    send("R5 argb4444", 4'd7, d,
         {16'b0, alpha[7:4], d[29:26], d[19:16], d[9:6]});
    send("R6 argb1555", 4'd8, d,
         {16'b0, alpha[7], d[29:25], d[19:15], d[9:5]});
    send("R7 rgb565", 4'd9, d,
         {16'b0, d[29:25], d[19:14], d[9:5]});
    send("R8 argb8888", 4'd10, d,
         {alpha, d[29:22], d[19:12], d[9:2]});
  endtask

  task automatic t_yuv_full;
    send("R9 full edges", 4'd11, {10'h3FF, 10'h002, 10'h001, 10'h1FE}, 32'hFF01_0080);
    send("R9 full mid",   4'd11, {10'h200, 10'h201, 10'h203, 10'h3FE}, 32'h8080_81FF);
  endtask

  task automatic t_yuv_lim;
    send("R10 lim edges", 4'd12, {10'h3FF, 10'h002, 10'h001, 10'h1FE}, 32'hEB10_1080);
    send("R10 lim top",   4'd12, {10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF}, 32'hEBEB_F0F0);
    send("R10 lim mid",   4'd12, {10'h200, 10'h3AC, 10'h3C0, 10'h040}, 32'h80EB_F010);
  endtask

  task automatic t_pass;
    send("R11 pass 13", 4'd13, 40'hA5_1234_5678, 32'h1234_5678);
    send("R11 pass 15", 4'd15, 40'h00_DEAD_BEEF, 32'hDEAD_BEEF);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    mode = 4'd10; in_data = 40'hFF_FFFF_FFFF; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R1 mid valid", {31'b0, out_valid}, 32'd0);
    chk("R1 mid data", out_data, 32'd0);
    in_valid = 1'b0; rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_raw();
    t_luma();
    t_rgb();
    t_yuv_full();
    t_yuv_lim();
    t_pass();
    t_reset_mid();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule